// File: doc/BRIEF.md
# Parity-Protected Universal Storage Register

This block is a small storage register of configurable width, built only from flip-flops on one clock. Each cycle it either holds its contents, loads a parallel word, or shifts one position toward the most significant bit, taking a serial bit in at the bottom. Synchronous clear and preset controls override these modes. A clock-enable input freezes the whole register when it is idle.

Every time the register is written, a parity bit is computed and stored next to the data. A read port returns the stored word only while it is both requested and enabled. While that port is open, parity is recomputed over the stored word and compared with the stored bit, and an error flag shows any disagreement, such as one upset bit. A test-only fault input can flip a single stored data bit without touching the stored parity, so the detection path can be exercised.

Top module: `parity_univ_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the stored word and the stored parity bit become 0.
- R2: While `ce` is low, no stored bit and no stored parity bit changes, whatever the other controls do.
- R3: With `ce` high, `clr` high makes the stored word and the stored parity 0 at the next edge. It overrides preset, writes and fault injection.
- R4: With `ce` high and `clr` low, `pre` high makes every stored bit 1 at the next edge, with parity equal to W mod 2. It overrides writes and fault injection.
- R5: With `ce` and `we` high, no clear or preset, and `mode` = 2'b01 (load), the stored word becomes `par_in` at the next edge.
- R6: With `ce` and `we` high, no clear or preset, and `mode` = 2'b10 (shift), bit 0 takes `ser_in` and bit i takes the old bit i-1. `ser_out` always shows stored bit W-1.
- R7: With `we` low, load and shift modes do not change the register.
- R8: `mode` values 2'b00 and 2'b11 hold the contents even when `we` is high.
- R9: `rd_valid` is high exactly when `re` is high and `oe_n` is low. At all other times `rd_data` is all zeros.
- R10: Every load or shift stores even parity (XOR of the new word). After any write, clear or preset, `par_err` stays low on a read.
- R11: With `ce` high and no clear, preset or write in that cycle, `inj_en` inverts stored bit `inj_idx` at the next edge and leaves the parity alone, so `par_err` goes high on a read. An index of W or more does nothing.
- R12: `par_err` is high only while `rd_valid` is high and the XOR of the stored word differs from the stored parity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Clock enable; low freezes all state |
| clr | input | 1 | Synchronous clear to all zeros |
| pre | input | 1 | Synchronous preset to all ones |
| we | input | 1 | Write enable for load and shift |
| mode | input | 2 | 00 hold, 01 load, 10 shift, 11 hold |
| par_in | input | W | Parallel load word |
| ser_in | input | 1 | Serial input into bit 0 |
| re | input | 1 | Read request |
| oe_n | input | 1 | Active-low output enable of the read port |
| inj_en | input | 1 | Test-only fault injection strobe |
| inj_idx | input | IW | Index of the bit to invert on injection |
| rd_data | output | W | Stored word when the read is valid, else zero |
| rd_valid | output | 1 | Read port active |
| par_err | output | 1 | Parity mismatch seen on an active read |
| ser_out | output | 1 | Stored bit W-1 |

## Verification
The bench builds the register with W = 7 rather than the default 8. With an odd width, preset stores parity 1 while clear stores 0, so a swapped preset parity becomes visible. A 3-bit injection index can then name position 7, which lies outside the word and must be ignored. A full run of shifts shows each serial bit reaching `ser_out` after exactly W cycles.

// File: rtl/parity_univ_reg_pkg.sv
// Package: shared mode encoding of the parity-protected storage register.
// Assumes a 2-bit mode field; both unused codes mean hold.
package parity_univ_reg_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD     = 2'b00,
        MODE_LOAD     = 2'b01,
        MODE_SHIFT    = 2'b10,
        MODE_HOLD_ALT = 2'b11
    } pur_mode_e;
endpackage

// File: rtl/pur_lane.sv
// Module: one bit lane of the storage register.
// Picks the shift or the load source with a 2:1 selection and applies the
// clear > preset > write > flip priority. Assumes the controls are qualified upstream.
module pur_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic clr,
    input  logic pre,
    input  logic wr,
    input  logic sel_shift,
    input  logic load_bit,
    input  logic shift_bit,
    input  logic flip,
    output logic q
);
    logic d_sel;

    // 2:1 source selection for this lane
    always_comb d_sel = sel_shift ? shift_bit : load_bit;

    // storage flip-flop with synchronous reset and clock enable
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (ce) begin
            if (clr)       q <= 1'b0;
            else if (pre)  q <= 1'b1;
            else if (wr)   q <= d_sel;
            else if (flip) q <= ~q;
        end
    end
endmodule

// File: rtl/pur_parity.sv
// Module: even-parity generator over a W-bit word.
// Purely combinational; assumes W >= 1.
module pur_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] word,
    output logic         par
);
    // XOR reduction of the word
    always_comb par = ^word;
endmodule

// File: rtl/pur_read_port.sv
// Module: gated read port with parity comparison.
// Drives the word only when the read is requested and enabled; zeros otherwise.
// Assumes the recomputed parity arrives from a separate generator.
module pur_read_port #(
    parameter int W = 8
) (
    input  logic         re,
    input  logic         oe_n,
    input  logic [W-1:0] q,
    input  logic         par_stored,
    input  logic         par_calc,
    output logic [W-1:0] rd_data,
    output logic         rd_valid,
    output logic         par_err
);
    // output gating and mismatch flag
    always_comb begin
        rd_valid = re & ~oe_n;
        rd_data  = rd_valid ? q : '0;
        par_err  = rd_valid & (par_stored ^ par_calc);
    end
endmodule

// File: rtl/parity_univ_reg.sv
// Module: parity-protected universal storage register (top).
// Hold / parallel load / serial shift-up with synchronous clear and preset,
// a stored even-parity bit checked on reads, and a test-only bit-flip input.
// Assumes W >= 2 and one rising-edge clock; rst_n is synchronous and active low.
module parity_univ_reg
    import parity_univ_reg_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          clr,
    input  logic          pre,
    input  logic          we,
    input  logic [1:0]    mode,
    input  logic [W-1:0]  par_in,
    input  logic          ser_in,
    input  logic          re,
    input  logic          oe_n,
    input  logic          inj_en,
    input  logic [IW-1:0] inj_idx,
    output logic [W-1:0]  rd_data,
    output logic          rd_valid,
    output logic          par_err,
    output logic          ser_out
);
    localparam logic PRE_PAR = logic'(W % 2);

    logic [W-1:0] q_r;
    logic [W-1:0] wr_word;
    logic [W-1:0] flip_vec;
    logic         par_r;
    logic         wr_par;
    logic         rd_par;
    logic         wr;
    logic         sel_shift;
    logic         inj_ok;

    // decode the mode field into write strobe and source select
    always_comb begin
        sel_shift = (pur_mode_e'(mode) == MODE_SHIFT);
        wr        = we & ((pur_mode_e'(mode) == MODE_LOAD) | sel_shift);
        inj_ok    = inj_en & ~clr & ~pre & ~wr;
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_lane
            logic shift_src;
            if (i == 0) begin : g_first
                assign shift_src = ser_in;
            end else begin : g_rest
                assign shift_src = q_r[i-1];
            end
            assign wr_word[i]  = sel_shift ? shift_src : par_in[i];
            assign flip_vec[i] = inj_ok & (32'(inj_idx) == i);

            pur_lane u_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .ce        (ce),
                .clr       (clr),
                .pre       (pre),
                .wr        (wr),
                .sel_shift (sel_shift),
                .load_bit  (par_in[i]),
                .shift_bit (shift_src),
                .flip      (flip_vec[i]),
                .q         (q_r[i])
            );
        end
    endgenerate

    pur_parity #(.W(W)) u_wr_par (.word(wr_word), .par(wr_par));
    pur_parity #(.W(W)) u_rd_par (.word(q_r),     .par(rd_par));

    // stored parity bit, following the same priority as the lanes
    always_ff @(posedge clk) begin
        if (!rst_n)      par_r <= 1'b0;
        else if (ce) begin
            if (clr)      par_r <= 1'b0;
            else if (pre) par_r <= PRE_PAR;
            else if (wr)  par_r <= wr_par;
        end
    end

    // serial output is the top stored bit
    always_comb ser_out = q_r[W-1];

    pur_read_port #(.W(W)) u_rd (
        .re         (re),
        .oe_n       (oe_n),
        .q          (q_r),
        .par_stored (par_r),
        .par_calc   (rd_par),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .par_err    (par_err)
    );
endmodule

// File: rtl/parity_univ_reg_chk.sv
// Module: assertion checker bound to parity_univ_reg.
// Watches ports and the stored word and parity; holds nothing of its own.
module parity_univ_reg_chk #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce,
    input logic          clr,
    input logic          pre,
    input logic          we,
    input logic [1:0]    mode,
    input logic          ser_in,
    input logic          re,
    input logic          oe_n,
    input logic          inj_en,
    input logic [IW-1:0] inj_idx,
    input logic [W-1:0]  rd_data,
    input logic          rd_valid,
    input logic          par_err,
    input logic [W-1:0]  q_r,
    input logic          par_r
);
    logic is_wr;
    // write strobe derived from the ports, not taken from the design
    always_comb is_wr = we & (mode == 2'b01 || mode == 2'b10);

    assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(q_r) && $stable(par_r)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && clr) |=> (q_r == '0 && par_r == 1'b0));

    assert_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !clr && pre) |=> (q_r == '1));

    assert_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !clr && !pre && we && mode == 2'b10) |=>
        (q_r[0] == $past(ser_in) && q_r[W-1:1] == $past(q_r[W-2:0])));

    assert_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !clr && !pre && !we && !inj_en) |=> $stable(q_r));

    assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(re && !oe_n) |-> (!rd_valid && rd_data == '0 && !par_err));

    assert_wrpar_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !clr && !pre && is_wr) |=> (par_r == ^q_r));

    assert_inject_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !clr && !pre && !is_wr && inj_en && 32'(inj_idx) < W) |=>
        ($countones(q_r ^ $past(q_r)) == 1 && $stable(par_r)));

    assert_errflag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> rd_valid);
endmodule

bind parity_univ_reg parity_univ_reg_chk #(.W(W), .IW(IW)) i_chk (
    .clk(clk), .rst_n(rst_n), .ce(ce), .clr(clr), .pre(pre), .we(we),
    .mode(mode), .ser_in(ser_in), .re(re), .oe_n(oe_n), .inj_en(inj_en),
    .inj_idx(inj_idx), .rd_data(rd_data), .rd_valid(rd_valid),
    .par_err(par_err), .q_r(q_r), .par_r(par_r)
);

// File: tb/test_parity_univ_reg.sv
// Bench for parity_univ_reg at W = 7: directed corners, then seeded random traffic.
module test_parity_univ_reg;
    localparam int W  = 7;
    localparam int IW = $clog2(W);

    logic          clk = 1'b0;
    logic          rst_n, ce, clr, pre, we, ser_in, re, oe_n, inj_en;
    logic [1:0]    mode;
    logic [W-1:0]  par_in;
    logic [IW-1:0] inj_idx;
    logic [W-1:0]  rd_data;
    logic          rd_valid, par_err, ser_out;

    logic [W-1:0]  m_q;
    logic          m_p;
    int            n_chk = 0;
    int            n_fail = 0;

    always #4 clk = ~clk;

    parity_univ_reg #(.W(W), .IW(IW)) i_parity_univ_reg (
        .clk(clk), .rst_n(rst_n), .ce(ce), .clr(clr), .pre(pre), .we(we),
        .mode(mode), .par_in(par_in), .ser_in(ser_in), .re(re), .oe_n(oe_n),
        .inj_en(inj_en), .inj_idx(inj_idx), .rd_data(rd_data),
        .rd_valid(rd_valid), .par_err(par_err), .ser_out(ser_out)
    );

    // expected next word, from the requirement text
    function automatic logic [W-1:0] f_next_q(logic [W-1:0] q);
        logic [W-1:0] n = q;
        if (!rst_n) n = '0;
        else if (ce) begin
            if (clr) n = '0;
            else if (pre) n = '1;
            else if (we && mode == 2'b01) n = par_in;
            else if (we && mode == 2'b10) n = {q[W-2:0], ser_in};
            else if (inj_en && int'(inj_idx) < W) n[inj_idx] = ~q[inj_idx];
        end
        return n;
    endfunction

    // expected next parity bit
    function automatic logic f_next_p(logic [W-1:0] q, logic p);
        logic n = p;
        if (!rst_n) n = 1'b0;
        else if (ce) begin
            if (clr) n = 1'b0;
            else if (pre) n = logic'(W % 2);
            else if (we && mode == 2'b01) n = ^par_in;
            else if (we && mode == 2'b10) n = ^{q[W-2:0], ser_in};
        end
        return n;
    endfunction

    task automatic chk(string rq, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", rq, got, exp);
        end
    endtask

    // one clock: advance the model at the edge, settle, return
    task automatic tick();
        logic [W-1:0] nq;
        logic np;
        @(posedge clk);
        nq = f_next_q(m_q);
        np = f_next_p(m_q, m_p);
        m_q = nq;
        m_p = np;
        #1;
    endtask

    task automatic check_read(string rq);
        if (re && !oe_n) begin
            chk(rq, 32'(rd_valid), 32'd1);
            chk(rq, 32'(rd_data), 32'(m_q));
            chk(rq, 32'(par_err), 32'(m_p != ^m_q));
        end else begin
            chk("R9", 32'(rd_valid), 32'd0);
            chk("R9", 32'(rd_data), 32'd0);
            chk("R12", 32'(par_err), 32'd0);
        end
        chk("R6", 32'(ser_out), 32'(m_q[W-1]));
    endtask

    task automatic idle();
        @(negedge clk);
        ce = 1'b1; clr = 1'b0; pre = 1'b0; we = 1'b0; mode = 2'b00;
        inj_en = 1'b0; inj_idx = '0; re = 1'b1; oe_n = 1'b0;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        m_q = '0; m_p = 1'b0;
        rst_n = 1'b0; ce = 1'b1; clr = 1'b0; pre = 1'b0; we = 1'b1;
        mode = 2'b01; par_in = 7'h2A; ser_in = 1'b0; re = 1'b1; oe_n = 1'b0;
        inj_en = 1'b0; inj_idx = '0;
        tick(); tick();
        chk("R1", 32'(rd_data), 32'd0);
        chk("R1", 32'(par_err), 32'd0);

        // R5 parallel load
        idle(); rst_n = 1'b1; we = 1'b1; mode = 2'b01; par_in = 7'h55;
        tick(); check_read("R5");
        // R7 load without write enable
        idle(); mode = 2'b01; par_in = 7'h0F;
        tick(); check_read("R7");
        chk("R7", 32'(rd_data), 32'h55);
        // R8 alternate hold code with we high
        idle(); we = 1'b1; mode = 2'b11; par_in = 7'h0F;
        tick(); check_read("R8");
        chk("R8", 32'(rd_data), 32'h55);
        // R6 shift a one through the whole word
        idle(); we = 1'b1; mode = 2'b10; ser_in = 1'b1;
        tick(); check_read("R6");
        ser_in = 1'b0;
        for (int k = 0; k < W; k++) begin
            tick(); check_read("R6");
        end
        // R2 clock enable low freezes even a clear
        idle(); par_in = 7'h33; we = 1'b1; mode = 2'b01; tick();
        idle(); ce = 1'b0; clr = 1'b1; pre = 1'b1;
        tick(); check_read("R2");
        chk("R2", 32'(rd_data), 32'h33);
        // R3 clear beats preset, load and injection
        idle(); clr = 1'b1; pre = 1'b1; we = 1'b1; mode = 2'b01; inj_en = 1'b1;
        tick(); check_read("R3");
        chk("R3", 32'(rd_data), 32'd0);
        // R4 preset beats load; odd width stores parity 1
        idle(); pre = 1'b1; we = 1'b1; mode = 2'b01; par_in = 7'h01;
        tick(); check_read("R4");
        chk("R4", 32'(rd_data), 32'h7F);
        chk("R4", 32'(par_err), 32'd0);
        // R11 injection flips bit 2 and the read flags it
        idle(); inj_en = 1'b1; inj_idx = 3'd2;
        tick(); check_read("R11");
        chk("R11", 32'(par_err), 32'd1);
        chk("R11", 32'(rd_data), 32'h7B);
        // R12 error hidden while the port is closed
        idle(); oe_n = 1'b1; #1;
        chk("R12", 32'(par_err), 32'd0);
        chk("R9", 32'(rd_data), 32'd0);
        idle(); re = 1'b0; #1;
        chk("R9", 32'(rd_valid), 32'd0);
        // R10 a load repairs parity
        idle(); we = 1'b1; mode = 2'b01; par_in = 7'h6C;
        tick(); check_read("R10");
        chk("R10", 32'(par_err), 32'd0);
        // R11 injection ignored during a write
        idle(); we = 1'b1; mode = 2'b01; par_in = 7'h11; inj_en = 1'b1; inj_idx = 3'd0;
        tick(); check_read("R11");
        chk("R11", 32'(rd_data), 32'h11);
        // R11 out-of-range index ignored
        idle(); inj_en = 1'b1; inj_idx = 3'd7;
        tick(); check_read("R11");
        chk("R11", 32'(rd_data), 32'h11);
        chk("R11", 32'(par_err), 32'd0);

        // seeded random traffic
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            ce      = ($urandom % 8) != 0;
            clr     = ($urandom % 20) == 0;
            pre     = ($urandom % 20) == 0;
            we      = ($urandom % 4) != 0;
            mode    = 2'($urandom);
            par_in  = W'($urandom);
            ser_in  = 1'($urandom);
            inj_en  = ($urandom % 10) == 0;
            inj_idx = IW'($urandom);
            re      = ($urandom % 8) != 0;
            oe_n    = ($urandom % 8) == 0;
            tick();
            check_read("R10");
        end
        finish_run();
    end
endmodule